// File: doc/BRIEF.md
# ADC output test pattern generator

This block sits on one channel's output path between the converter core and the output serializer. On every sample clock it chooses the word to send. The choices are the live converter sample, a constant all-zeros or all-ones word, a word that alternates between two complementary bit patterns, a free-running ramp across the full code range, or a fixed word that software assembles from two configuration registers. A receiver can lock onto these known sequences to confirm that every bit lane and the word framing arrive intact.

After the pattern is chosen, a number-format stage gives the word as two's complement or as offset binary. A digital-enable input overrides the pattern select and forces the live sample path. The output is registered, so a word appears one clock after the inputs that produce it. The sample-valid strobe is carried through with the same one-cycle delay.

Top module: `adc_test_pattern_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, that edge loads `out_word` with 0 and `out_valid` with 0. The first word after reset release comes from the inputs present at the first edge with `rst` low.
- R2: When `pat_sel` is 000 and `dig_en` is 1, `out_word` equals `in_data` from the previous edge, with the format of R10 applied. `out_valid` always equals `in_valid` from the previous edge.
- R3: `pat_sel` 001 gives a word of all zeros, and `pat_sel` 010 gives all 14 bits set (0x3FFF), before formatting. `in_data` has no effect in either mode.
- R4: `pat_sel` 011 gives 0x2AAA (binary 10101010101010) and 0x1555 (binary 01010101010101) on alternate clocks, starting with 0x2AAA.
- R5: `pat_sel` 100 gives a ramp that starts at 0 and rises by one code per clock. It wraps from 16383 back to 0.
- R6: The ramp restarts at 0, and the alternating pattern restarts at 0x2AAA, on the first clock that its mode is in effect after reset or after any other mode.
- R7: `pat_sel` 101 gives the word `{custom_hi[5:0], custom_lo[7:0]}`. `custom_hi` supplies bits 13..8 and `custom_lo` supplies bits 7..0.
- R8: `pat_sel` values 110 and 111 behave exactly like 000.
- R9: When `dig_en` is 0, the block behaves as if `pat_sel` were 000, whatever value `pat_sel` holds.
- R10: When `fmt_sel` is 11, bit 13 of the chosen word is inverted (offset binary). Values 00, 01 and 10 leave the word unchanged (two's complement). The format applies to test patterns as well as to live data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 14 | Converter sample, two's complement |
| in_valid | input | 1 | Strobe qualifying `in_data` |
| pat_sel | input | 3 | Pattern select (000 live, 001 zeros, 010 ones, 011 alternate, 100 ramp, 101 custom, 11x live) |
| custom_hi | input | 6 | Custom word bits 13..8 |
| custom_lo | input | 8 | Custom word bits 7..0 |
| fmt_sel | input | 2 | Number format: 11 offset binary, else two's complement |
| dig_en | input | 1 | Digital-function enable; 0 forces live data |
| out_word | output | 14 | Registered output word |
| out_valid | output | 1 | `in_valid` delayed by one clock |

## Verification
The ramp is run past 16383 so that the wrap to 0 is seen. A counter that saturated or was sized wrongly would stall or skip codes there. Both sequence modes are left for a single clock and then entered again. A generator that only cleared on reset would resume mid-sequence instead of at 0 or 0x2AAA. Constant, custom and sequence words are all sent through offset binary, which exposes a format stage placed before the pattern mux or one that flips the wrong bit. The reserved selects and a cleared `dig_en` are driven with live data present, so a design that decoded them as patterns would show a constant in place of the sample.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    // Pattern select codes; the numeric values are the external encoding.
    typedef enum logic [2:0] {
        SEL_LIVE   = 3'b000,
        SEL_ZEROS  = 3'b001,
        SEL_ONES   = 3'b010,
        SEL_ALT    = 3'b011,
        SEL_RAMP   = 3'b100,
        SEL_CUSTOM = 3'b101,
        SEL_RSVD_A = 3'b110,
        SEL_RSVD_B = 3'b111
    } pat_sel_e;

    // Only one format code selects offset binary.
    localparam logic [1:0] FMT_OFFSET_CODE = 2'b11;

    // Variant selector for the sequence generator.
    localparam int SEQ_RAMP = 0;
    localparam int SEQ_ALT  = 1;

    // Decoded per-cycle control for the datapath.
    typedef struct packed {
        pat_sel_e sel;          // effective select after enable/reserved folding
        logic     offset_bin;   // invert MSB at the output
        logic     ramp_active;
        logic     ramp_restart; // first cycle of ramp mode
        logic     alt_active;
        logic     alt_restart;  // first cycle of alternating mode
    } tpg_ctrl_t;

    // Fold the disable and reserved codes onto the live path.
    function automatic pat_sel_e resolve_sel(input logic [2:0] raw, input logic en);
        pat_sel_e s;
        if (!en) begin
            s = SEL_LIVE;
        end else begin
            case (raw)
                3'b110, 3'b111: s = SEL_LIVE;
                default:        s = pat_sel_e'(raw);
            endcase
        end
        return s;
    endfunction

    function automatic logic is_offset_fmt(input logic [1:0] f);
        return (f == FMT_OFFSET_CODE);
    endfunction

    // Alternating word of width w whose MSB is 1: bits w-1, w-3, ... set.
    function automatic logic [63:0] alt_word_msb_one(input int w);
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < w; i++) begin
            r[i] = ((w - 1 - i) % 2) == 0;
        end
        return r;
    endfunction

endpackage

// File: rtl/tpg_ctrl_decode.sv
module tpg_ctrl_decode
    import tpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] pat_sel,
    input  logic       dig_en,
    input  logic [1:0] fmt_sel,
    output tpg_ctrl_t  ctrl
);

    pat_sel_e eff_sel;
    pat_sel_e prev_sel_q;
    logic     ramp_now;
    logic     alt_now;

    always_comb begin
        eff_sel  = resolve_sel(pat_sel, dig_en);
        ramp_now = (eff_sel == SEL_RAMP);
        alt_now  = (eff_sel == SEL_ALT);
    end

    // Remember the effective mode of the last cycle to spot mode entry.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sel_q <= SEL_LIVE;
        end else begin
            prev_sel_q <= eff_sel;
        end
    end

    always_comb begin
        ctrl.sel          = eff_sel;
        ctrl.offset_bin   = is_offset_fmt(fmt_sel);
        ctrl.ramp_active  = ramp_now;
        ctrl.ramp_restart = ramp_now && (prev_sel_q != SEL_RAMP);
        ctrl.alt_active   = alt_now;
        ctrl.alt_restart  = alt_now && (prev_sel_q != SEL_ALT);
    end

endmodule

// File: rtl/tpg_seq_gen.sv
module tpg_seq_gen
    import tpg_pkg::*;
#(
    parameter int W    = 14,
    parameter int KIND = SEQ_RAMP
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic         restart,
    output logic [W-1:0] value
);

    localparam logic [W-1:0] ONE   = {{(W-1){1'b0}}, 1'b1};
    localparam logic [63:0]  ALT64 = alt_word_msb_one(W);
    localparam logic [W-1:0] ALT_A = ALT64[W-1:0];
    localparam logic [W-1:0] ALT_B = ~ALT_A;

    generate
        if (KIND == SEQ_RAMP) begin : g_ramp
            logic [W-1:0] cnt_q;
            logic [W-1:0] cur;

            // On entry the current word is forced to 0, then counting resumes.
            assign cur   = restart ? '0 : cnt_q;
            assign value = cur;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                end else if (active) begin
                    cnt_q <= cur + ONE;   // natural wrap at full range
                end
            end
        end else begin : g_alt
            logic phase_q;
            logic cur_phase;

            assign cur_phase = restart ? 1'b0 : phase_q;
            assign value     = cur_phase ? ALT_B : ALT_A;

            always_ff @(posedge clk) begin
                if (rst) begin
                    phase_q <= 1'b0;
                end else if (active) begin
                    phase_q <= ~cur_phase;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/tpg_word_select.sv
module tpg_word_select
    import tpg_pkg::*;
#(
    parameter int W    = 14,
    parameter int LO_W = 8
) (
    input  pat_sel_e          sel,
    input  logic              offset_bin,
    input  logic [W-1:0]      live_data,
    input  logic [W-1:0]      ramp_val,
    input  logic [W-1:0]      alt_val,
    input  logic [W-LO_W-1:0] custom_hi,
    input  logic [LO_W-1:0]   custom_lo,
    output logic [W-1:0]      word
);

    localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] chosen;

    always_comb begin
        case (sel)
            SEL_ZEROS:  chosen = '0;
            SEL_ONES:   chosen = '1;
            SEL_ALT:    chosen = alt_val;
            SEL_RAMP:   chosen = ramp_val;
            SEL_CUSTOM: chosen = {custom_hi, custom_lo};
            default:    chosen = live_data;
        endcase
    end

    // Format after pattern choice: offset binary is the MSB flipped.
    assign word = offset_bin ? (chosen ^ MSB_MASK) : chosen;

endmodule

// File: rtl/adc_test_pattern_gen.sv
module adc_test_pattern_gen
    import tpg_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int LO_W   = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [DATA_W-1:0]      in_data,
    input  logic                   in_valid,
    input  logic [2:0]             pat_sel,
    input  logic [DATA_W-LO_W-1:0] custom_hi,
    input  logic [LO_W-1:0]        custom_lo,
    input  logic [1:0]             fmt_sel,
    input  logic                   dig_en,
    output logic [DATA_W-1:0]      out_word,
    output logic                   out_valid
);

    tpg_ctrl_t         ctrl;
    logic [DATA_W-1:0] ramp_val;
    logic [DATA_W-1:0] alt_val;
    logic [DATA_W-1:0] next_word;

    tpg_ctrl_decode u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .pat_sel (pat_sel),
        .dig_en  (dig_en),
        .fmt_sel (fmt_sel),
        .ctrl    (ctrl)
    );

    tpg_seq_gen #(.W(DATA_W), .KIND(SEQ_RAMP)) u_ramp (
        .clk     (clk),
        .rst     (rst),
        .active  (ctrl.ramp_active),
        .restart (ctrl.ramp_restart),
        .value   (ramp_val)
    );

    tpg_seq_gen #(.W(DATA_W), .KIND(SEQ_ALT)) u_alt (
        .clk     (clk),
        .rst     (rst),
        .active  (ctrl.alt_active),
        .restart (ctrl.alt_restart),
        .value   (alt_val)
    );

    tpg_word_select #(.W(DATA_W), .LO_W(LO_W)) u_sel (
        .sel        (ctrl.sel),
        .offset_bin (ctrl.offset_bin),
        .live_data  (in_data),
        .ramp_val   (ramp_val),
        .alt_val    (alt_val),
        .custom_hi  (custom_hi),
        .custom_lo  (custom_lo),
        .word       (next_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_word  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_word  <= next_word;
            out_valid <= in_valid;
        end
    end

endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
    parameter int DATA_W = 14,
    parameter int LO_W   = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic [DATA_W-1:0]      in_data,
    input logic                   in_valid,
    input logic [2:0]             pat_sel,
    input logic [DATA_W-LO_W-1:0] custom_hi,
    input logic [LO_W-1:0]        custom_lo,
    input logic [1:0]             fmt_sel,
    input logic                   dig_en,
    input logic [DATA_W-1:0]      out_word,
    input logic                   out_valid
);

    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    logic armed;
    logic armed2;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b0;
            armed2 <= 1'b0;
        end else begin
            armed  <= 1'b1;
            armed2 <= armed;
        end
    end

    logic live_m, zero_m, ones_m, alt_m, ramp_m, cust_m, ofs;
    always_comb begin
        live_m = !dig_en || pat_sel == 3'b000 || pat_sel == 3'b110 || pat_sel == 3'b111;
        zero_m = dig_en && pat_sel == 3'b001;
        ones_m = dig_en && pat_sel == 3'b010;
        alt_m  = dig_en && pat_sel == 3'b011;
        ramp_m = dig_en && pat_sel == 3'b100;
        cust_m = dig_en && pat_sel == 3'b101;
        ofs    = fmt_sel == 2'b11;
    end

    p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
        armed |-> (out_valid == $past(in_valid)));

    // R8 and R9 fold onto the live path checked here.
    p_live_pass_r2: assert property (@(posedge clk) disable iff (rst)
        armed && $past(live_m && !ofs) |-> (out_word == $past(in_data)));

    p_zeros_r3: assert property (@(posedge clk) disable iff (rst)
        armed && $past(zero_m && !ofs) |-> (out_word == '0));

    p_ones_r3: assert property (@(posedge clk) disable iff (rst)
        armed && $past(ones_m && !ofs) |-> (out_word == '1));

    p_zero_offset_r10: assert property (@(posedge clk) disable iff (rst)
        armed && $past(zero_m && ofs) |-> (out_word == {1'b1, {(DATA_W-1){1'b0}}}));

    p_alt_flip_r4: assert property (@(posedge clk) disable iff (rst)
        armed2 && $past(alt_m && !ofs) && $past(alt_m && !ofs, 2)
        |-> (out_word == ~$past(out_word)));

    p_ramp_step_r5: assert property (@(posedge clk) disable iff (rst)
        armed2 && $past(ramp_m) && $past(ramp_m, 2) && ($past(fmt_sel) == $past(fmt_sel, 2))
        |-> (out_word == $past(out_word) + ONE));

    p_ramp_entry_r6: assert property (@(posedge clk) disable iff (rst)
        armed2 && $past(ramp_m && !ofs) && !$past(ramp_m, 2) |-> (out_word == '0));

    p_custom_r7: assert property (@(posedge clk) disable iff (rst)
        armed && $past(cust_m && !ofs) |-> (out_word == {$past(custom_hi), $past(custom_lo)}));

endmodule

bind adc_test_pattern_gen tpg_checker #(.DATA_W(DATA_W), .LO_W(LO_W)) u_tpg_checker (
    .clk       (clk),
    .rst       (rst),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .pat_sel   (pat_sel),
    .custom_hi (custom_hi),
    .custom_lo (custom_lo),
    .fmt_sel   (fmt_sel),
    .dig_en    (dig_en),
    .out_word  (out_word),
    .out_valid (out_valid)
);

// File: tb/tb_adc_test_pattern_gen.sv
`timescale 1ns/1ps
module tb_adc_test_pattern_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic [13:0] in_data;
    logic        in_valid;
    logic [2:0]  pat_sel;
    logic [5:0]  custom_hi;
    logic [7:0]  custom_lo;
    logic [1:0]  fmt_sel;
    logic        dig_en;
    logic [13:0] out_word;
    logic        out_valid;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    adc_test_pattern_gen dut (
        .clk       (clk),
        .rst       (rst),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .pat_sel   (pat_sel),
        .custom_hi (custom_hi),
        .custom_lo (custom_lo),
        .fmt_sel   (fmt_sel),
        .dig_en    (dig_en),
        .out_word  (out_word),
        .out_valid (out_valid)
    );

    task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // {req[3:0], sel[2:0], fmt[1:0], en, data[13:0], hi[5:0], lo[7:0], expected[13:0]}
    localparam int NV = 12;
    localparam logic [51:0] VEC [NV] = '{
        {4'd2,  3'd0, 2'b00, 1'b1, 14'h1234, 6'h00, 8'h00, 14'h1234}, // R2 live
        {4'd10, 3'd0, 2'b11, 1'b1, 14'h1234, 6'h00, 8'h00, 14'h3234}, // R10 live offset
        {4'd3,  3'd1, 2'b00, 1'b1, 14'h1234, 6'h00, 8'h00, 14'h0000}, // R3 zeros
        {4'd10, 3'd1, 2'b11, 1'b1, 14'h1234, 6'h00, 8'h00, 14'h2000}, // R10 zeros offset
        {4'd3,  3'd2, 2'b01, 1'b1, 14'h0000, 6'h00, 8'h00, 14'h3FFF}, // R3 ones
        {4'd10, 3'd2, 2'b11, 1'b1, 14'h0000, 6'h00, 8'h00, 14'h1FFF}, // R10 ones offset
        {4'd7,  3'd5, 2'b10, 1'b1, 14'h0777, 6'h2A, 8'h5C, 14'h2A5C}, // R7 custom
        {4'd10, 3'd5, 2'b11, 1'b1, 14'h0777, 6'h2A, 8'h5C, 14'h0A5C}, // R10 custom offset
        {4'd8,  3'd6, 2'b00, 1'b1, 14'h0F0F, 6'h3F, 8'hFF, 14'h0F0F}, // R8 reserved 110
        {4'd8,  3'd7, 2'b11, 1'b1, 14'h0F0F, 6'h3F, 8'hFF, 14'h2F0F}, // R8 reserved 111
        {4'd9,  3'd1, 2'b00, 1'b0, 14'h1111, 6'h00, 8'h00, 14'h1111}, // R9 disabled zeros
        {4'd9,  3'd5, 2'b11, 1'b0, 14'h1111, 6'h15, 8'hAA, 14'h3111}  // R9 disabled custom
    };

    initial begin
        rst = 1'b1; in_valid = 1'b1; in_data = 14'h3ABC; pat_sel = 3'd2;
        custom_hi = '0; custom_lo = '0; fmt_sel = 2'b00; dig_en = 1'b1;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", out_word, 14'h0000);
        check("R1", {13'b0, out_valid}, 14'd0);
        rst = 1'b0;

        // Table of static modes
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            pat_sel   = VEC[i][47:45];
            fmt_sel   = VEC[i][44:43];
            dig_en    = VEC[i][42];
            in_data   = VEC[i][41:28];
            custom_hi = VEC[i][27:22];
            custom_lo = VEC[i][21:14];
            in_valid  = 1'b1;
            @(negedge clk);
            check($sformatf("R%0d", VEC[i][51:48]), out_word, VEC[i][13:0]);
            check("R2", {13'b0, out_valid}, 14'd1);
        end

        // R2: valid follows strobe
        in_valid = 1'b0; pat_sel = 3'd0; dig_en = 1'b1; fmt_sel = 2'b00; in_data = 14'h0042;
        @(negedge clk);
        check("R2", {13'b0, out_valid}, 14'd0);
        check("R2", out_word, 14'h0042);

        // R4: alternating words
        in_valid = 1'b1; pat_sel = 3'd3;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R4", out_word, (k % 2 == 1) ? 14'h1555 : 14'h2AAA);
        end
        // leave for one cycle mid-sequence, then re-enter: R6
        pat_sel = 3'd0; in_data = 14'h0ABC;
        @(negedge clk);
        check("R2", out_word, 14'h0ABC);
        pat_sel = 3'd3;
        @(negedge clk);
        check("R6", out_word, 14'h2AAA);
        @(negedge clk);
        check("R4", out_word, 14'h1555);

        // R5: full ramp through the wrap
        pat_sel = 3'd4;
        for (int k = 0; k < 16387; k++) begin
            @(negedge clk);
            check("R5", out_word, k[13:0]);
        end

        // R6: leave ramp for one cycle, re-enter
        pat_sel = 3'd1;
        @(negedge clk);
        check("R3", out_word, 14'h0000);
        pat_sel = 3'd4;
        @(negedge clk);
        check("R6", out_word, 14'h0000);
        @(negedge clk);
        check("R6", out_word, 14'h0001);
        fmt_sel = 2'b11;
        @(negedge clk);
        check("R10", out_word, 14'h2002);

        // R1 mid-ramp, then restart after release
        rst = 1'b1;
        @(negedge clk);
        check("R1", out_word, 14'h0000);
        check("R1", {13'b0, out_valid}, 14'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R6", out_word, 14'h2000);

        // R9: clearing enable mid-ramp gives live data
        dig_en = 1'b0; fmt_sel = 2'b00; in_data = 14'h0123;
        @(negedge clk);
        check("R9", out_word, 14'h0123);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule